// File: doc/BRIEF.md
# Integer Ordering and Byte-Lane Match Unit

This unit accepts two 32-bit operands, called A and B, together with a two-bit operation code. It returns one registered result word. In the two compare modes the result is the difference B minus A. When the operands' top bits disagree, the difference's top bit is overwritten. The corrected top bit then reports the ordering of the operands under a signed or an unsigned reading. A plain sign test on the result therefore tells software which operand is larger, even when the subtraction overflows.

The third mode scans the operands one byte lane at a time. The scan begins at the most significant lane. The result is the 1-based number of the first lane in which both operands hold the same byte, or zero when no lane matches. Results appear one clock after a valid input. The output word keeps its value through cycles in which no input is offered.

Top module: `ordmatch_unit`

## Requirements
- R1: On a synchronous reset (rst_i high at a rising edge), out_valid_o and result_o both become zero.
- R2: out_valid_o equals the value in_valid_i had at the previous rising edge. One result is delivered per accepted input, and back-to-back inputs are allowed.
- R3: While in_valid_i is low at a rising edge, result_o keeps its previous value, whatever op_i, opa_i and opb_i hold.
- R4: In either compare mode (op_i = 2'b00 signed, op_i = 2'b01 unsigned), when bit 31 of A equals bit 31 of B, the result is B minus A modulo 2^32.
- R5: In signed compare (op_i = 2'b00), when bit 31 of A differs from bit 31 of B, result bit 31 equals bit 31 of B. Bits 30:0 equal bits 30:0 of B minus A.
- R6: In unsigned compare (op_i = 2'b01), when bit 31 of A differs from bit 31 of B, result bit 31 equals bit 31 of A. Bits 30:0 equal bits 30:0 of B minus A.
- R7: In byte-match mode (op_i = 2'b10), lanes are numbered 1 (bits 31:24), 2 (bits 23:16), 3 (bits 15:8) and 4 (bits 7:0). The result is the lowest-numbered lane whose A and B bytes are equal.
- R8: In byte-match mode, the result is zero when no lane has equal bytes. In every byte-match result, bits 31:3 are zero.
- R9: For op_i = 2'b11 the result is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_i | input | 1 | Synchronous reset, active high |
| in_valid_i | input | 1 | Operands and op code are offered this cycle |
| op_i | input | 2 | 00 signed compare, 01 unsigned compare, 10 byte match, 11 zero |
| opa_i | input | 32 | Operand A (subtrahend) |
| opb_i | input | 32 | Operand B (minuend) |
| out_valid_o | output | 1 | result_o holds a new result |
| result_o | output | 32 | Registered compare difference or lane index |

## Verification
The assertions assume that in_valid_i, op_i and both operands are free of X at every rising edge outside reset. They also assume that no reset pulse falls between an accepted input and the cycle that checks it. The stimulus drives every input to a known value at the falling edge before each rising edge. It asserts reset only at the start and in one directed test, and each property checks the cycle after an edge where reset was low.

// File: rtl/ordmatch_pkg.sv
package ordmatch_pkg;

    localparam int OM_DATA_W = 32;
    localparam int OM_LANE_W = 8;
    localparam int OM_OP_W   = 2;

    typedef enum logic [OM_OP_W-1:0] {
        OP_SCMP  = 2'b00,
        OP_UCMP  = 2'b01,
        OP_BMAT  = 2'b10,
        OP_NONE  = 2'b11
    } opsel_e;

endpackage

// File: rtl/ordmatch_diff.sv
// Subtracts A from B and repairs the top bit so that it reports ordering.
module ordmatch_diff #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              signed_i,
    output logic [DATA_W-1:0] diff_o
);
    localparam int TOP = DATA_W - 1;

    logic [DATA_W-1:0] raw_d;
    logic              sign_split_d;
    logic              fixed_top_d;

    always_comb begin
        raw_d        = b_i + ~a_i + DATA_W'(1);
        sign_split_d = a_i[TOP] ^ b_i[TOP];
        fixed_top_d  = signed_i ? b_i[TOP] : a_i[TOP];
        diff_o       = raw_d;
        if (sign_split_d) begin
            diff_o[TOP] = fixed_top_d;
        end
    end
endmodule

// File: rtl/ordmatch_lanes.sv
// Finds the first equal byte lane counting from the most significant lane.
module ordmatch_lanes #(
    parameter int DATA_W = 32,
    parameter int LANE_W = 8
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] idx_o
);
    localparam int NUM_LANES = DATA_W / LANE_W;
    localparam int IDX_W     = $clog2(NUM_LANES + 1);

    logic [NUM_LANES-1:0] hit_d;
    logic [IDX_W-1:0]     first_d;

    // hit_d[k] belongs to lane k+1, where lane 1 is the most significant byte
    for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
        localparam int HI = DATA_W - 1 - k * LANE_W;
        assign hit_d[k] = (a_i[HI -: LANE_W] == b_i[HI -: LANE_W]);
    end

    always_comb begin
        first_d = '0;
        for (int k = NUM_LANES - 1; k >= 0; k--) begin
            if (hit_d[k]) begin
                first_d = IDX_W'(k + 1);
            end
        end
        idx_o = {{(DATA_W - IDX_W){1'b0}}, first_d};
    end
endmodule

// File: rtl/ordmatch_unit.sv
module ordmatch_unit #(
    parameter int DATA_W = ordmatch_pkg::OM_DATA_W,
    parameter int LANE_W = ordmatch_pkg::OM_LANE_W
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              in_valid_i,
    input  logic [1:0]        op_i,
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    output logic              out_valid_o,
    output logic [DATA_W-1:0] result_o
);
    import ordmatch_pkg::*;

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] res;
    } stage_t;

    stage_t            st_d, st_q;
    logic [DATA_W-1:0] cmp_res_d;
    logic [DATA_W-1:0] lane_res_d;
    opsel_e            op_d;

    assign op_d = opsel_e'(op_i);

    ordmatch_diff #(.DATA_W(DATA_W)) diff_i (
        .a_i      (opa_i),
        .b_i      (opb_i),
        .signed_i (op_d == OP_SCMP),
        .diff_o   (cmp_res_d)
    );

    ordmatch_lanes #(.DATA_W(DATA_W), .LANE_W(LANE_W)) lanes_i (
        .a_i   (opa_i),
        .b_i   (opb_i),
        .idx_o (lane_res_d)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid_i;
        if (in_valid_i) begin
            unique case (op_d)
                OP_SCMP, OP_UCMP: st_d.res = cmp_res_d;
                OP_BMAT:          st_d.res = lane_res_d;
                default:          st_d.res = '0;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid_o = st_q.vld;
    assign result_o    = st_q.res;
endmodule

// File: rtl/ordmatch_unit_chk.sv
module ordmatch_unit_chk #(
    parameter int DATA_W = 32,
    parameter int LANE_W = 8
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              in_valid_i,
    input logic [1:0]        op_i,
    input logic [DATA_W-1:0] opa_i,
    input logic [DATA_W-1:0] opb_i,
    input logic              out_valid_o,
    input logic [DATA_W-1:0] result_o
);
    localparam int NUM_LANES = DATA_W / LANE_W;
    localparam int IDX_W     = $clog2(NUM_LANES + 1);
    localparam int TOP       = DATA_W - 1;

    // R2
    vld_follow_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        in_valid_i |=> out_valid_o);

    // R2
    vld_idle_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !in_valid_i |=> !out_valid_o);

    // R3
    hold_res_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !in_valid_i |=> $stable(result_o));

    // R5
    signed_top_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (in_valid_i && op_i == 2'b00 && (opa_i[TOP] != opb_i[TOP]))
        |=> (result_o[TOP] == $past(opb_i[TOP])));

    // R6
    unsigned_top_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (in_valid_i && op_i == 2'b01 && (opa_i[TOP] != opb_i[TOP]))
        |=> (result_o[TOP] == $past(opa_i[TOP])));

    // R8
    lane_range_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (in_valid_i && op_i == 2'b10)
        |=> (result_o[DATA_W-1:IDX_W] == '0));

    // R9
    null_op_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (in_valid_i && op_i == 2'b11) |=> (result_o == '0));
endmodule

bind ordmatch_unit ordmatch_unit_chk #(.DATA_W(DATA_W), .LANE_W(LANE_W)) chk_i (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .in_valid_i  (in_valid_i),
    .op_i        (op_i),
    .opa_i       (opa_i),
    .opb_i       (opb_i),
    .out_valid_o (out_valid_o),
    .result_o    (result_o)
);

// File: tb/ordmatch_unit_tb_top.sv
module ordmatch_unit_tb_top;

    typedef struct packed {
        logic [1:0]  op;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NVEC = 15;
    localparam vec_t VECS [NVEC] = '{
        '{2'b00, 32'h0000_0005, 32'h0000_0003, 32'hFFFF_FFFE, 8'd4},
        '{2'b00, 32'h0000_0003, 32'h0000_0005, 32'h0000_0002, 8'd4},
        '{2'b00, 32'h8000_0000, 32'h8000_0000, 32'h0000_0000, 8'd4},
        '{2'b00, 32'h8000_0000, 32'h0000_0001, 32'h0000_0001, 8'd5},
        '{2'b00, 32'h0000_0001, 32'h8000_0000, 32'hFFFF_FFFF, 8'd5},
        '{2'b01, 32'h8000_0000, 32'h0000_0001, 32'h8000_0001, 8'd6},
        '{2'b01, 32'h0000_0001, 32'h8000_0000, 32'h7FFF_FFFF, 8'd6},
        '{2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000, 8'd4},
        '{2'b01, 32'h0000_0010, 32'h7FFF_FFFF, 32'h7FFF_FFEF, 8'd4},
        '{2'b10, 32'h1234_5678, 32'h1200_0000, 32'h0000_0001, 8'd7},
        '{2'b10, 32'h1122_3344, 32'h0022_3300, 32'h0000_0002, 8'd7},
        '{2'b10, 32'h0102_CC03, 32'h0000_CC00, 32'h0000_0003, 8'd7},
        '{2'b10, 32'h0102_03DD, 32'h0000_00DD, 32'h0000_0004, 8'd7},
        '{2'b10, 32'h0102_0304, 32'h1020_3040, 32'h0000_0000, 8'd8},
        '{2'b11, 32'h0000_1234, 32'h0000_5678, 32'h0000_0000, 8'd9}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [1:0]  op;
    logic [31:0] opa, opb;
    logic        out_valid;
    logic [31:0] result;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    ordmatch_unit dut_i (
        .clk_i       (clk),
        .rst_i       (rst),
        .in_valid_i  (in_valid),
        .op_i        (op),
        .opa_i       (opa),
        .opb_i       (opb),
        .out_valid_o (out_valid),
        .result_o    (result)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [1:0] o, input logic [31:0] a, input logic [31:0] b);
        in_valid = v;
        op       = o;
        opa      = a;
        opb      = b;
        @(negedge clk);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000 && !done) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected below 5000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] held;
        rst = 1'b1;
        in_valid = 1'b1;
        op = 2'b00;
        opa = 32'h1;
        opb = 32'h2;
        @(negedge clk);
        @(negedge clk);
        check("R1 valid after reset", 32'(out_valid), 32'd0);
        check("R1 result after reset", result, 32'd0);
        rst = 1'b0;

        // table walk, one vector per cycle (back-to-back, R2)
        for (int i = 0; i < NVEC; i++) begin
            drive(1'b1, VECS[i].op, VECS[i].a, VECS[i].b);
            check($sformatf("R%0d vec %0d", VECS[i].req, i), result, VECS[i].exp);
            check("R2 out_valid high", 32'(out_valid), 32'd1);
        end

        // R3: idle cycles leave the result unchanged despite new operands
        drive(1'b1, 2'b00, 32'h0000_0001, 32'h0000_0009);
        check("R4 before hold", result, 32'h0000_0008);
        held = result;
        drive(1'b0, 2'b11, 32'hDEAD_BEEF, 32'h0BAD_F00D);
        check("R3 hold after idle", result, held);
        check("R2 out_valid low", 32'(out_valid), 32'd0);
        drive(1'b0, 2'b10, 32'hAAAA_AAAA, 32'hAAAA_AAAA);
        check("R3 hold second idle", result, held);

        // R7: several lanes equal, the most significant wins
        drive(1'b1, 2'b10, 32'h00FF_00FF, 32'h11FF_22FF);
        check("R7 earliest lane", result, 32'h0000_0002);
        drive(1'b1, 2'b10, 32'hCAFE_F00D, 32'hCAFE_F00D);
        check("R7 all lanes", result, 32'h0000_0001);

        // R1: mid-run reset clears both outputs
        in_valid = 1'b1;
        op = 2'b00;
        opa = 32'h0;
        opb = 32'h1234_5678;
        rst = 1'b1;
        @(negedge clk);
        check("R1 mid-run valid", 32'(out_valid), 32'd0);
        check("R1 mid-run result", result, 32'd0);
        rst = 1'b0;
        drive(1'b1, 2'b00, 32'h0, 32'h1234_5678);
        check("R4 after reset", result, 32'h1234_5678);
        drive(1'b0, 2'b00, 32'h0, 32'h0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule